// File: doc/BRIEF.md
# Dual-Slot Accumulator Processor

A multicycle accumulator processor that runs from a synchronous single-port memory of 40-bit words. Each word packs two 20-bit instructions, and each instruction is an 8-bit opcode followed by a 12-bit address. The program counter addresses instruction pairs. The first instruction of a fetched pair runs at once. The second is parked in a buffer register and runs next without another memory read.

The datapath holds an accumulator and a multiplier-quotient register, both 40-bit two's complement. Arithmetic wraps modulo 2^40. Multiply and divide are iterative, one bit per cycle, and the sequencer waits for them to finish. Two stores rewrite only the address field of a memory word, so a program can patch its own instructions.

The memory port works like this. A read request in one cycle returns its data on the read-data bus in the next cycle. A write completes at the clock edge where it is requested. A synchronous active-high reset restarts execution at word 0. The processor raises its halt output when it stops.

Top module: `acc40_core`

## Requirements
- R1: In the first cycle after reset is released, the processor requests a read of word 0 with write low, and halted is low.
- R2: The instruction in word bits [39:20] runs before the one in bits [19:0]. In each instruction, bits [19:12] are the opcode and bits [11:0] are the address X. A fetched pair costs one memory read. The second instruction comes from the buffer and causes no extra read.
- R3: Transfer opcodes: 0x01 sets AC=M(X), 0x02 sets AC=-M(X), 0x03 sets AC=|M(X)|, 0x04 sets AC=-|M(X)|, 0x09 sets MQ=M(X), 0x0A sets AC=MQ, and 0x21 writes AC to M(X). All results wrap modulo 2^40.
- R4: 0x05 adds M(X) to AC, 0x06 subtracts M(X) from AC, 0x07 adds |M(X)| to AC and 0x08 subtracts |M(X)| from AC.
- R5: 0x0D continues at the first instruction of word X. 0x0E continues at the second instruction of word X, and the first instruction of that word is never run. A buffered second instruction of the jumping word is discarded.
- R6: 0x0F and 0x10 behave like 0x0D and 0x0E when AC bit 39 is 0. Otherwise execution continues in sequence.
- R7: 0x0B forms the signed 80-bit product M(X)×MQ. The upper 40 bits go to AC and the lower 40 bits go to MQ.
- R8: 0x0C divides AC by M(X) with truncation toward zero. The quotient goes to MQ. The remainder goes to AC and takes the sign of the dividend.
- R9: 0x14 shifts AC left by one bit, dropping bit 39. 0x15 shifts AC right by one bit, keeping the sign.
- R10: 0x12 replaces bits [31:20] of M(X) with AC[11:0], and 0x13 replaces bits [11:0] of M(X) with AC[11:0]. All other bits are kept. A patched instruction takes effect when its word is next fetched.
- R11: Opcode 0x00, or any opcode not listed in R3 to R10, stops the processor. halted then stays high and no memory request is made until reset.
- R12: A divide whose divisor M(X) is zero halts the processor and writes nothing to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts at word 0 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 12 | Word address |
| mem_wdata | output | 40 | Write data |
| mem_rdata | input | 40 | Read data, valid one cycle after a read request |
| halted | output | 1 | Processor has stopped |

## Verification
Two functions can collide in one cycle. The first collision happens when a taken jump is decided while the second instruction of the same word still sits valid in the buffer. The jump's redirect and the buffer's pending issue then compete for the next slot. Programs place jumps in first slots, with stores to sentinel words in the second slots. The test is judged by the sentinels staying untouched while stores placed at the jump targets land. The second collision happens when an address-field store patches the word that will be fetched next. It is provoked by patching two stores in the following word and then checking where those stores wrote.

// File: rtl/acc40_pkg.sv
package acc40_pkg;

    localparam logic [7:0] OP_HALT  = 8'h00;
    localparam logic [7:0] OP_LD    = 8'h01;
    localparam logic [7:0] OP_LDN   = 8'h02;
    localparam logic [7:0] OP_LDA   = 8'h03;
    localparam logic [7:0] OP_LDNA  = 8'h04;
    localparam logic [7:0] OP_ADD   = 8'h05;
    localparam logic [7:0] OP_SUB   = 8'h06;
    localparam logic [7:0] OP_ADDA  = 8'h07;
    localparam logic [7:0] OP_SUBA  = 8'h08;
    localparam logic [7:0] OP_LDMQ  = 8'h09;
    localparam logic [7:0] OP_MQ2AC = 8'h0A;
    localparam logic [7:0] OP_MUL   = 8'h0B;
    localparam logic [7:0] OP_DIV   = 8'h0C;
    localparam logic [7:0] OP_JL    = 8'h0D;
    localparam logic [7:0] OP_JR    = 8'h0E;
    localparam logic [7:0] OP_JPL   = 8'h0F;
    localparam logic [7:0] OP_JPR   = 8'h10;
    localparam logic [7:0] OP_SETL  = 8'h12;
    localparam logic [7:0] OP_SETR  = 8'h13;
    localparam logic [7:0] OP_SHL   = 8'h14;
    localparam logic [7:0] OP_SHR   = 8'h15;
    localparam logic [7:0] OP_ST    = 8'h21;

    typedef enum logic [2:0] {
        ST_FETCH, ST_FWAIT, ST_SPLIT, ST_EXEC,
        ST_OPRD,  ST_OPEX,  ST_MD,    ST_HALT
    } state_e;

    function automatic logic needs_operand(input logic [7:0] op);
        return (op >= OP_LD && op <= OP_LDMQ) || op == OP_MUL || op == OP_DIV ||
               op == OP_SETL || op == OP_SETR;
    endfunction

    function automatic logic is_jump(input logic [7:0] op);
        return op >= OP_JL && op <= OP_JPR;
    endfunction

    function automatic logic jump_to_right(input logic [7:0] op);
        return op == OP_JR || op == OP_JPR;
    endfunction

    function automatic logic jump_is_cond(input logic [7:0] op);
        return op == OP_JPL || op == OP_JPR;
    endfunction

endpackage

// File: rtl/acc40_alu.sv
module acc40_alu
    import acc40_pkg::*;
#(
    parameter int W = 40
) (
    input  logic [7:0]   op,
    input  logic [W-1:0] ac,
    input  logic [W-1:0] mq,
    input  logic [W-1:0] m,
    output logic [W-1:0] res
);
    logic [W-1:0] mag;

    always_comb begin
        mag = m[W-1] ? -m : m;
        case (op)
            OP_LD:    res = m;
            OP_LDN:   res = -m;
            OP_LDA:   res = mag;
            OP_LDNA:  res = -mag;
            OP_ADD:   res = ac + m;
            OP_SUB:   res = ac - m;
            OP_ADDA:  res = ac + mag;
            OP_SUBA:  res = ac - mag;
            OP_MQ2AC: res = mq;
            OP_SHL:   res = {ac[W-2:0], 1'b0};
            OP_SHR:   res = {ac[W-1], ac[W-1:1]};
            default:  res = ac;
        endcase
    end
endmodule

// File: rtl/acc40_muldiv.sv
module acc40_muldiv #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         is_div,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] res_ac,
    output logic [W-1:0] res_mq
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     hi, lo, mb;
    logic             div_r, neg_a, neg_b;
    logic [W:0]       sum, shv, diff;
    logic [2*W-1:0]   prod;

    always_comb begin
        sum  = {1'b0, hi} + (lo[0] ? {1'b0, mb} : '0);
        shv  = {hi, lo[W-1]};
        diff = shv - {1'b0, mb};
        prod = (neg_a ^ neg_b) ? -{hi, lo} : {hi, lo};
        if (div_r) begin
            res_mq = (neg_a ^ neg_b) ? -lo : lo;
            res_ac = neg_a ? -hi : hi;
        end else begin
            res_ac = prod[2*W-1:W];
            res_mq = prod[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0; hi <= '0; lo <= '0; mb <= '0;
            div_r <= 1'b0; neg_a <= 1'b0; neg_b <= 1'b0;
            busy <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                hi    <= '0;
                lo    <= a[W-1] ? -a : a;
                mb    <= b[W-1] ? -b : b;
                neg_a <= a[W-1];
                neg_b <= b[W-1];
                div_r <= is_div;
                cnt   <= '0;
                busy  <= 1'b1;
            end else if (busy) begin
                if (div_r) begin
                    if (!diff[W]) begin
                        hi <= diff[W-1:0];
                        lo <= {lo[W-2:0], 1'b1};
                    end else begin
                        hi <= shv[W-1:0];
                        lo <= {lo[W-2:0], 1'b0};
                    end
                end else begin
                    hi <= sum[W:1];
                    lo <= {sum[0], lo[W-1:1]};
                end
                cnt <= cnt + 1'b1;
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R7
    start_idle_chk: assert property (@(posedge clk) disable iff (rst) start |-> !busy);
    // R8
    done_follows_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> $past(busy));
endmodule

// File: rtl/acc40_core.sv
module acc40_core
    import acc40_pkg::*;
#(
    parameter int WORD_W = 40,
    parameter int ADDR_W = 12,
    parameter int OP_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              halted
);
    localparam int INS_W = WORD_W / 2;

    state_e            state;
    logic [ADDR_W-1:0] pc, mar;
    logic [WORD_W-1:0] mbr, ac, mq;
    logic [OP_W-1:0]   ir;
    logic [INS_W-1:0]  ibr, sel_half;
    logic              ibr_v, want_right;
    logic [WORD_W-1:0] alu_res, md_ac, md_mq, rmw_word;
    logic              md_start, md_busy, md_done;

    acc40_alu #(.W(WORD_W)) u_alu (
        .op(ir), .ac(ac), .mq(mq), .m(mbr), .res(alu_res)
    );

    acc40_muldiv #(.W(WORD_W)) u_md (
        .clk(clk), .rst(rst), .start(md_start), .is_div(ir == OP_DIV),
        .a((ir == OP_MUL) ? mq : ac), .b(mbr),
        .busy(md_busy), .done(md_done), .res_ac(md_ac), .res_mq(md_mq)
    );

    always_comb begin
        sel_half = want_right ? mbr[INS_W-1:0] : mbr[WORD_W-1 -: INS_W];
        rmw_word = mbr;
        if (ir == OP_SETL) rmw_word[INS_W +: ADDR_W] = ac[ADDR_W-1:0];
        else               rmw_word[0 +: ADDR_W]     = ac[ADDR_W-1:0];
        md_start = (state == ST_OPEX) && (ir == OP_MUL || (ir == OP_DIV && mbr != '0));
        halted   = (state == ST_HALT);
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = mar;
        mem_wdata = ac;
        case (state)
            ST_FETCH: if (!ibr_v) begin
                mem_req  = 1'b1;
                mem_addr = pc;
            end
            ST_EXEC: if (needs_operand(ir)) mem_req = 1'b1;
                     else if (ir == OP_ST) begin
                         mem_req = 1'b1;
                         mem_we  = 1'b1;
                     end
            ST_OPEX: if (ir == OP_SETL || ir == OP_SETR) begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = rmw_word;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH; pc <= '0; mar <= '0; mbr <= '0;
            ac <= '0; mq <= '0; ir <= '0; ibr <= '0;
            ibr_v <= 1'b0; want_right <= 1'b0;
        end else begin
            case (state)
                ST_FETCH: if (ibr_v) begin
                    ir    <= ibr[INS_W-1 -: OP_W];
                    mar   <= ibr[ADDR_W-1:0];
                    ibr_v <= 1'b0;
                    state <= ST_EXEC;
                end else state <= ST_FWAIT;
                ST_FWAIT: begin
                    mbr   <= mem_rdata;
                    state <= ST_SPLIT;
                end
                ST_SPLIT: begin
                    ir         <= sel_half[INS_W-1 -: OP_W];
                    mar        <= sel_half[ADDR_W-1:0];
                    ibr        <= mbr[INS_W-1:0];
                    ibr_v      <= !want_right;
                    want_right <= 1'b0;
                    pc         <= pc + 1'b1;
                    state      <= ST_EXEC;
                end
                ST_EXEC: begin
                    state <= ST_FETCH;
                    if (needs_operand(ir)) state <= ST_OPRD;
                    else if (ir == OP_MQ2AC || ir == OP_SHL || ir == OP_SHR) ac <= alu_res;
                    else if (is_jump(ir)) begin
                        if (!jump_is_cond(ir) || !ac[WORD_W-1]) begin
                            pc         <= mar;
                            want_right <= jump_to_right(ir);
                            ibr_v      <= 1'b0;
                        end
                    end else if (ir != OP_ST) state <= ST_HALT;
                end
                ST_OPRD: begin
                    mbr   <= mem_rdata;
                    state <= ST_OPEX;
                end
                ST_OPEX: begin
                    state <= ST_FETCH;
                    case (ir)
                        OP_LDMQ:          mq <= mbr;
                        OP_MUL:           state <= ST_MD;
                        OP_DIV:           state <= (mbr == '0) ? ST_HALT : ST_MD;
                        OP_SETL, OP_SETR: ;
                        default:          ac <= alu_res;
                    endcase
                end
                ST_MD: if (md_done) begin
                    ac    <= md_ac;
                    mq    <= md_mq;
                    state <= ST_FETCH;
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    // R11
    halt_silent_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !mem_req));
    // R2
    buffer_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH && ibr_v) |-> !mem_req);
    // R12
    divzero_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OPEX && ir == OP_DIV && mbr == '0) |=> (halted && !mem_we));
    // R3
    write_from_store_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_req && (ir == OP_ST || ir == OP_SETL || ir == OP_SETR)));
    // R7
    md_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MD && md_busy) |=> (state == ST_MD));
endmodule

// File: tb/acc40_core_tb.sv
`timescale 1ns/1ps
module acc40_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req, mem_we, halted;
    logic [11:0] mem_addr;
    logic [39:0] mem_wdata;
    logic [39:0] rdata = '0;

    logic        clr = 1'b0, ld_en = 1'b0;
    logic [7:0]  ld_a = '0;
    logic [39:0] ld_d = '0;
    logic [39:0] mem [256];
    int nrd = 0, nwr = 0, nchk = 0, nbad = 0;

    localparam logic [39:0] SENT = 40'hDEAD;
    localparam logic [39:0] MINV = 40'h80_0000_0000;

    always #4 clk = ~clk;

    acc40_core u_dut (
        .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(rdata), .halted(halted)
    );

    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
            nrd <= 0; nwr <= 0;
        end else if (ld_en) mem[ld_a] <= ld_d;
        else if (!rst && mem_req) begin
            if (mem_we) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                nwr <= nwr + 1;
            end else begin
                rdata <= mem[mem_addr[7:0]];
                nrd <= nrd + 1;
            end
        end
    end

    function automatic logic [39:0] wd(logic [7:0] o1, int a1, logic [7:0] o2, int a2);
        return {o1, 12'(a1), o2, 12'(a2)};
    endfunction

    function automatic logic [39:0] mag(logic [39:0] x);
        return x[39] ? -x : x;
    endfunction

    function automatic logic [39:0] val(int i);
        case (i)
            0: return 40'd0;
            1: return 40'd1;
            2: return -40'd1;
            3: return 40'd5;
            4: return -40'd7;
            5: return 40'h7F_FFFF_FFFF;
            6: return MINV;
            default: return 40'd123456789;
        endcase
    endfunction

    task automatic chk(string tag, logic [39:0] act, logic [39:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic prep();
        @(negedge clk); rst = 1'b1; clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic put(int a, logic [39:0] d);
        @(negedge clk); ld_en = 1'b1; ld_a = a[7:0]; ld_d = d;
        @(negedge clk); ld_en = 1'b0;
    endtask

    task automatic go(int lim);
        bit fin;
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 first address", {28'b0, mem_addr}, 40'd0);
        chk("R1 req/we/halted", {37'b0, mem_req, mem_we, halted}, 40'b100);
        fin = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (halted) begin fin = 1'b1; break; end
        end
        if (!fin) begin
            nchk++; nbad++;
            $display("FAIL R11 halted act=0 exp=1 (run timeout)");
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        logic signed [39:0] a, b;
        logic signed [79:0] p;
        int r0, w0;

        // R3 and R2: transfers, read count for pairs
        prep();
        put(0, wd(8'h01, 100, 8'h21, 110));
        put(1, wd(8'h02, 100, 8'h21, 111));
        put(2, wd(8'h03, 101, 8'h21, 112));
        put(3, wd(8'h04, 101, 8'h21, 113));
        put(4, wd(8'h09, 102, 8'h0A, 0));
        put(5, wd(8'h21, 114, 8'h00, 0));
        put(100, 40'd12345); put(101, -40'd777); put(102, 40'hA_BCDE);
        go(2000);
        chk("R3 load", mem[110], 40'd12345);
        chk("R3 load negative", mem[111], -40'd12345);
        chk("R3 load magnitude", mem[112], 40'd777);
        chk("R3 load negative magnitude", mem[113], -40'd777);
        chk("R3 MQ path", mem[114], 40'hA_BCDE);
        chk("R2 read count", 40'(nrd), 40'd11);
        chk("R2 write count", 40'(nwr), 40'd5);

        // R4: add/subtract sweep
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                a = val(i); b = val(j);
                prep();
                put(0, wd(8'h01, 100, 8'h05, 101));
                put(1, wd(8'h21, 110, 8'h01, 100));
                put(2, wd(8'h06, 101, 8'h21, 111));
                put(3, wd(8'h01, 100, 8'h07, 101));
                put(4, wd(8'h21, 112, 8'h01, 100));
                put(5, wd(8'h08, 101, 8'h21, 113));
                put(6, wd(8'h00, 0, 8'h00, 0));
                put(100, a); put(101, b);
                go(2000);
                chk("R4 add", mem[110], a + b);
                chk("R4 sub", mem[111], a - b);
                chk("R4 add magnitude", mem[112], a + mag(b));
                chk("R4 sub magnitude", mem[113], a - mag(b));
            end
        end

        // R7: multiply sweep
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                a = val(i); b = val(j);
                p = a * b;
                prep();
                put(0, wd(8'h09, 101, 8'h0B, 100));
                put(1, wd(8'h21, 110, 8'h0A, 0));
                put(2, wd(8'h21, 111, 8'h00, 0));
                put(100, a); put(101, b);
                go(2000);
                chk("R7 product high", mem[110], p[79:40]);
                chk("R7 product low", mem[111], p[39:0]);
            end
        end

        // R8: divide sweep
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                a = val(i); b = val(j);
                if (b == 0 || (a == MINV && b == -1)) continue;
                prep();
                put(0, wd(8'h01, 100, 8'h0C, 101));
                put(1, wd(8'h21, 110, 8'h0A, 0));
                put(2, wd(8'h21, 111, 8'h00, 0));
                put(100, a); put(101, b);
                go(2000);
                chk("R8 remainder", mem[110], a % b);
                chk("R8 quotient", mem[111], a / b);
            end
        end

        // R12: divide by zero
        prep();
        put(0, wd(8'h01, 100, 8'h0C, 101));
        put(1, wd(8'h21, 110, 8'h00, 0));
        put(100, 40'd99); put(110, SENT);
        go(2000);
        chk("R12 halted", {39'b0, halted}, 40'd1);
        chk("R12 no store", mem[110], SENT);
        chk("R12 no write", 40'(nwr), 40'd0);

        // R9: shift sweep
        for (int i = 0; i < 8; i++) begin
            a = val(i);
            prep();
            put(0, wd(8'h01, 100, 8'h14, 0));
            put(1, wd(8'h21, 110, 8'h01, 100));
            put(2, wd(8'h15, 0, 8'h21, 111));
            put(3, wd(8'h00, 0, 8'h00, 0));
            put(100, a);
            go(2000);
            chk("R9 shift left", mem[110], a <<< 1);
            chk("R9 shift right", mem[111], a >>> 1);
        end

        // R5 and R6: jumps and buffer discard
        prep();
        put(0,  wd(8'h01, 100, 8'h0E, 3));
        put(1,  wd(8'h21, 120, 8'h00, 0));
        put(3,  wd(8'h21, 121, 8'h21, 122));
        put(4,  wd(8'h0D, 6,   8'h21, 123));
        put(6,  wd(8'h0F, 8,   8'h21, 124));
        put(8,  wd(8'h02, 100, 8'h10, 10));
        put(9,  wd(8'h21, 125, 8'h01, 101));
        put(10, wd(8'h10, 12,  8'h21, 126));
        put(12, wd(8'h21, 127, 8'h21, 128));
        put(100, 40'd5); put(101, 40'd0);
        for (int k = 120; k <= 128; k++) put(k, SENT);
        go(2000);
        chk("R5 jump right skips sequence", mem[120], SENT);
        chk("R5 jump right skips left", mem[121], SENT);
        chk("R5 jump right target", mem[122], 40'd5);
        chk("R5 buffered half discarded", mem[123], SENT);
        chk("R6 taken discards buffer", mem[124], SENT);
        chk("R6 negative falls through", mem[125], -40'd5);
        chk("R6 zero taken", mem[126], SENT);
        chk("R6 right target skips left", mem[127], SENT);
        chk("R6 right target runs", mem[128], 40'd0);

        // R10: address-field stores and self-patching
        prep();
        put(0, wd(8'h01, 100, 8'h13, 2));
        put(1, wd(8'h12, 2,   8'h01, 101));
        put(2, wd(8'h21, 0,   8'h21, 0));
        put(3, wd(8'h12, 105, 8'h13, 106));
        put(100, 40'd107); put(101, 40'h5A_5A5A_5ABC);
        put(105, 40'h12_3456_789A); put(106, 40'hFE_DCBA_9876);
        go(2000);
        chk("R10 patched word", mem[2], wd(8'h21, 107, 8'h21, 107));
        chk("R10 patched store target", mem[107], 40'h5A_5A5A_5ABC);
        chk("R10 word 0 untouched", mem[0], wd(8'h01, 100, 8'h13, 2));
        chk("R10 left field", mem[105], (40'h12_3456_789A & ~(40'hFFF << 20)) | (40'hABC << 20));
        chk("R10 right field", mem[106], (40'hFE_DCBA_9876 & ~40'hFFF) | 40'hABC);

        // R11: undefined opcodes halt and go silent
        for (int k = 0; k < 3; k++) begin
            prep();
            put(0, wd((k == 0) ? 8'h11 : (k == 1) ? 8'h33 : 8'hFF, 0, 8'h21, 110));
            put(110, SENT);
            go(2000);
            r0 = nrd; w0 = nwr;
            repeat (20) @(negedge clk);
            chk("R11 halted held", {39'b0, halted}, 40'd1);
            chk("R11 no later store", mem[110], SENT);
            chk("R11 single fetch", 40'(nrd), 40'd1);
            chk("R11 silent", 40'(nrd - r0 + nwr - w0), 40'd0);
        end

        // R1: reset after halt releases the stop
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk("R1 halted cleared in reset", {39'b0, halted}, 40'd0);

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule